// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor word port and a slower main-memory word port and keeps a direct-mapped cache of multi-word lines. Each processor address is split into a tag, a line index and a word offset; the index picks a single line, whose stored tag and valid bit decide between a hit and a miss. A miss brings in the whole line from memory one word at a time, after first copying a modified victim line back out.

A mode input picks the write policy per request. In write-through mode every processor write goes to memory, and the cached word is updated as well when it is present. A write miss allocates nothing. In write-back mode writes touch only the cache and flag the line as modified; memory sees the data when that line is displaced. A write miss first allocates the line and then writes into it. Two counters, one for lookups and one for hits, let software work out the hit ratio.

Both ports use a request/ready handshake. The processor raises `cpu_req` with its command and holds it until it sees `cpu_ready`. The memory port moves one word in each cycle where `mem_req` and `mem_ready` are both high.

Top module: `wbc_cache`

## Requirements
- R1: With default parameters, address bits [2:0] are the word offset, [5:3] the line index and [11:6] the tag. A read hit returns the cached word with `cpu_ready` in the cycle after the request is taken, and no memory transfer.
- R2: After synchronous active-low reset, all lines are invalid and clean, both counters read 0, and `cpu_ready` and `mem_req` are low. A dirty line present before reset is dropped without a write-back.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. Otherwise the line is replaced, unless the access is a write-through write.
- R4: A fill reads the 8 words of the line in ascending offset order starting at offset 0. The line then becomes valid and clean, and the original access completes from the cache.
- R5: In write-through mode each write makes exactly one memory write at the request address. It also updates the cached word when that word hits. `cpu_ready` comes with the memory handshake.
- R6: In write-back mode a write hit updates only the cache, marks the line dirty, and makes no memory transfer.
- R7: A write miss in write-through mode allocates no line; a later read of that address misses.
- R8: A write miss in write-back mode fills the line and then writes the word into it, so the next read of that address hits.
- R9: A miss on a valid dirty line first writes all 8 of its words back to the victim's own addresses. No refill read happens before the last of these writes.
- R10: The reference counter rises by one for each accepted request. The hit counter rises by one when that request's first lookup hits. Neither counts the repeat lookup after a fill, and hits never exceed references.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back; sampled when the request is taken |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts or returns a word this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| hit_count | output | CNT_W | Hits on first lookup |
| ref_count | output | CNT_W | Accepted processor requests |

## Verification
On every cycle the assertions check that fill reads step through consecutive word addresses, that no memory write follows a memory read before the processor is answered, that each counter moves by at most one with hits never exceeding references, and that both ports are quiet just after reset. Which accesses hit, how many words each miss writes back and reads, whether write-back data really reaches memory only on eviction, that write-through misses leave the cache untouched, and that reset drops a dirty line all depend on sequences of accesses. Only the bench's scenarios can show these, by comparing the returned data, the counter changes and its own memory model against expected values.

// File: rtl/wbc_pkg.sv
// Package: shared types for the direct-mapped cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package wbc_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a processor request
        ST_LOOKUP,  // tag compare on the captured request
        ST_EVICT,   // copying a dirty victim line out to memory
        ST_FILL,    // reading the requested line from memory
        ST_WTHRU    // single write-through memory write
    } wbc_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
// Module: per-line valid, dirty and tag state for a direct-mapped cache.
// Assumes: a single line index is in use at a time. A fill makes the line
// valid and clean. Reset clears valid and dirty but leaves the tags alone.
module wbc_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Purpose: valid and dirty flags, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (dirty_en) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    // Purpose: tag storage, written when a fill completes
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    // Purpose: present the indexed line's state
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
    end

endmodule

// File: rtl/wbc_data_store.sv
// Module: word storage for all cache lines, addressed by {index, offset}.
// Assumes: combinational read, one synchronous write port, no reset.
module wbc_data_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Purpose: single-port word write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Purpose: asynchronous word read
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/wbc_stats.sv
// Module: reference and hit counters for hit-ratio measurement.
// Assumes: hit_inc only rises together with ref_inc. The counters wrap.
module wbc_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_inc,
    input  logic             hit_inc,
    output logic [CNT_W-1:0] ref_count,
    output logic [CNT_W-1:0] hit_count
);
    // Purpose: count references and hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_count <= '0;
            hit_count <= '0;
        end else begin
            if (ref_inc) ref_count <= ref_count + CNT_W'(1);
            if (hit_inc) hit_count <= hit_count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wbc_cache.sv
// Module: direct-mapped cache controller with selectable write policy.
// Assumes: the requester holds cpu_req and its command steady until
// cpu_ready. The memory completes one word per cycle with mem_ready.
// wt_mode is sampled when a request is taken.
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 3,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  ref_count
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int DAW   = IDX_W + OFF_W;

    wbc_state_e        state_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              req_we_q;
    logic              req_wt_q;
    logic              retry_q;
    logic [OFF_W-1:0]  beat_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              hit, last_beat, xfer;
    logic              fill_done, wr_cache, dirty_set;
    logic              dwr_en;
    logic [DAW-1:0]    drd_addr, dwr_addr;
    logic [DATA_W-1:0] drd_data, dwr_data;

    // Purpose: split the captured address and form hit and beat flags
    always_comb begin
        req_tag   = req_addr_q[ADDR_W-1 -: TAG_W];
        req_idx   = req_addr_q[OFF_W +: IDX_W];
        req_off   = req_addr_q[OFF_W-1:0];
        hit       = line_valid && (line_tag == req_tag);
        last_beat = &beat_q;
        xfer      = mem_req && mem_ready;
    end

    // Purpose: request capture, sequencing and beat counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_we_q    <= 1'b0;
            req_wt_q    <= 1'b0;
            retry_q     <= 1'b0;
            beat_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        req_we_q    <= cpu_we;
                        req_wt_q    <= wt_mode;
                        retry_q     <= 1'b0;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    beat_q <= '0;
                    if (req_we_q && req_wt_q) begin
                        state_q <= ST_WTHRU;
                    end else if (hit) begin
                        state_q <= ST_IDLE;
                    end else if (line_valid && line_dirty) begin
                        state_q <= ST_EVICT;
                    end else begin
                        state_q <= ST_FILL;
                    end
                end
                ST_EVICT: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + OFF_W'(1);
                        if (last_beat) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + OFF_W'(1);
                        if (last_beat) begin
                            retry_q <= 1'b1;
                            state_q <= ST_LOOKUP;
                        end
                    end
                end
                ST_WTHRU: begin
                    if (mem_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: cache update controls for fills and processor writes
    always_comb begin
        fill_done = (state_q == ST_FILL) && mem_ready && last_beat;
        wr_cache  = (state_q == ST_LOOKUP) && hit && req_we_q;
        dirty_set = wr_cache && !req_wt_q;
        dwr_en    = wr_cache || ((state_q == ST_FILL) && mem_ready);
        dwr_addr  = wr_cache ? {req_idx, req_off} : {req_idx, beat_q};
        dwr_data  = wr_cache ? req_wdata_q : mem_rdata;
        drd_addr  = (state_q == ST_EVICT) ? {req_idx, beat_q} : {req_idx, req_off};
    end

    // Purpose: drive both ports from the current state
    always_comb begin
        cpu_ready = ((state_q == ST_LOOKUP) && hit && !(req_we_q && req_wt_q))
                 || ((state_q == ST_WTHRU) && mem_ready);
        cpu_rdata = drd_data;
        mem_req   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_WTHRU);
        mem_we    = (state_q == ST_EVICT) || (state_q == ST_WTHRU);
        mem_wdata = (state_q == ST_EVICT) ? drd_data : req_wdata_q;
        case (state_q)
            ST_EVICT: mem_addr = {line_tag, req_idx, beat_q};
            ST_FILL:  mem_addr = {req_tag, req_idx, beat_q};
            default:  mem_addr = req_addr_q;
        endcase
    end

    wbc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .fill_en    (fill_done),
        .fill_tag   (req_tag),
        .dirty_en   (dirty_set)
    );

    wbc_data_store #(.DATA_W(DATA_W), .AW(DAW)) u_data (
        .clk     (clk),
        .rd_addr (drd_addr),
        .rd_data (drd_data),
        .wr_en   (dwr_en),
        .wr_addr (dwr_addr),
        .wr_data (dwr_data)
    );

    wbc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_inc   ((state_q == ST_LOOKUP) && !retry_q),
        .hit_inc   ((state_q == ST_LOOKUP) && !retry_q && hit),
        .ref_count (ref_count),
        .hit_count (hit_count)
    );

    // xfer kept for checker visibility of completed memory beats
    logic unused_ok;
    assign unused_ok = xfer;

endmodule

// File: rtl/wbc_cache_chk.sv
// Module: port-level property checker for wbc_cache, bound to every instance.
// Assumes: synchronous active-low reset is held for at least one clock.
module wbc_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 3,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  ref_count
);
    // R2: ports quiet and counters zero in the first cycle after reset
    assert_quiet_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_req && !cpu_ready && hit_count == '0 && ref_count == '0));

    // R4: fill reads walk consecutive word addresses
    assert_fill_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && !(&mem_addr[OFF_W-1:0]))
        |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R9: no memory write follows a memory read before the processor is answered
    assert_no_write_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && mem_we));

    // R10: hits never exceed references
    assert_hits_le_refs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= ref_count);

    // R10: references advance by at most one per cycle
    assert_ref_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ref_count == $past(ref_count) || ref_count == $past(ref_count) + CNT_W'(1)));

    // R10: hits advance by at most one per cycle
    assert_hit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (hit_count == $past(hit_count) || hit_count == $past(hit_count) + CNT_W'(1)));

endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .hit_count (hit_count),
    .ref_count (ref_count)
);

// File: tb/wbc_cache_tb.sv
`timescale 1ns/1ps
module wbc_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wt_mode = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [31:0] hit_count, ref_count;

    always #10 clk = ~clk;   // 50 MHz

    wbc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .ref_count(ref_count)
    );

    function automatic logic [15:0] init_word(input logic [11:0] a);
        return {a, 4'h0} ^ 16'h5A3C;
    endfunction

    // Memory model: ready every other cycle, counts beats and ordering faults
    logic [15:0] mem_model [4096];
    logic        mem_inited = 1'b0;
    logic        phase = 1'b0;
    logic        rd_pending = 1'b0;
    int          wr_cnt = 0, rd_cnt = 0, order_viol = 0;

    assign mem_ready = mem_req && phase;
    assign mem_rdata = mem_model[mem_addr];

    always @(posedge clk) begin
        if (!mem_inited) begin
            for (int i = 0; i < 4096; i++) mem_model[i] <= init_word(12'(i));
            mem_inited <= 1'b1;
        end
        phase <= rst_n ? ~phase : 1'b0;
        if (!rst_n) begin
            rd_pending <= 1'b0;
        end else begin
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem_model[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                    if (rd_pending) order_viol <= order_viol + 1;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                    rd_pending <= 1'b1;
                end
            end
            if (cpu_ready) rd_pending <= 1'b0;
        end
    end

    logic [15:0] gold [4096];
    int total = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One processor access; returns read data and counter/beat deltas
    task automatic access(input logic we, input logic [11:0] a, input logic [15:0] d,
                          input logic wt, output logic [15:0] rd, output int dh,
                          output int dr, output int dw, output int drd);
        int h0, r0, w0, rr0, n;
        h0 = hit_count; r0 = ref_count; w0 = wr_cnt; rr0 = rd_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; wt_mode = wt;
        n = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
            n++;
            if (n > 500) begin
                chk(1'b0, "R1", "access timeout", 0, 1);
                break;
            end
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        dh = hit_count - h0; dr = ref_count - r0; dw = wr_cnt - w0; drd = rd_cnt - rr0;
        if (we) gold[a] = d;
    endtask

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [15:0] wdata;
        logic        exp_hit;
        logic [3:0]  exp_wr;
        logic [3:0]  exp_rd;
    } vec_t;

    // Write-back mode sequence: index field is addr[5:3], tag addr[11:6]
    localparam vec_t VECS [10] = '{
        '{1'b0, 12'h000, 16'h0000, 1'b0, 4'd0, 4'd8},  // cold miss
        '{1'b0, 12'h005, 16'h0000, 1'b1, 4'd0, 4'd0},  // same line hit
        '{1'b1, 12'h003, 16'h1111, 1'b1, 4'd0, 4'd0},  // write hit, dirty
        '{1'b0, 12'h003, 16'h0000, 1'b1, 4'd0, 4'd0},  // read back
        '{1'b0, 12'h040, 16'h0000, 1'b0, 4'd8, 4'd8},  // conflict, dirty evict
        '{1'b0, 12'h003, 16'h0000, 1'b0, 4'd0, 4'd8},  // clean victim, data from memory
        '{1'b1, 12'h18A, 16'h2222, 1'b0, 4'd0, 4'd8},  // write miss allocates
        '{1'b0, 12'h18A, 16'h0000, 1'b1, 4'd0, 4'd0},  // hit after allocate
        '{1'b0, 12'h00F, 16'h0000, 1'b0, 4'd8, 4'd8},  // evicts dirty idx 1
        '{1'b0, 12'h18A, 16'h0000, 1'b0, 4'd0, 4'd8}   // refetch written data
    };

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total + 1);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int dh, dr, dw, drd;
        for (int i = 0; i < 4096; i++) gold[i] = init_word(12'(i));
        repeat (4) @(negedge clk);
        chk(cpu_ready == 1'b0, "R2", "cpu_ready in reset", cpu_ready, 0);
        chk(mem_req == 1'b0, "R2", "mem_req in reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_count == 0 && ref_count == 0, "R2", "counters after reset", ref_count, 0);

        for (int i = 0; i < 10; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, 1'b0, rd, dh, dr, dw, drd);
            chk(dr == 1, "R10", $sformatf("vec %0d ref delta", i), dr, 1);
            chk(dh == int'(VECS[i].exp_hit), (i == 7) ? "R8" : "R3",
                $sformatf("vec %0d hit", i), dh, VECS[i].exp_hit);
            chk(dw == int'(VECS[i].exp_wr), (i == 2) ? "R6" : "R9",
                $sformatf("vec %0d write beats", i), dw, VECS[i].exp_wr);
            chk(drd == int'(VECS[i].exp_rd), "R4", $sformatf("vec %0d read beats", i), drd, VECS[i].exp_rd);
            if (!VECS[i].we)
                chk(rd == gold[VECS[i].addr], "R1", $sformatf("vec %0d data", i), rd, gold[VECS[i].addr]);
        end
        chk(order_viol == 0, "R9", "write after refill read", order_viol, 0);
        chk(ref_count == 10, "R10", "total references", ref_count, 10);
        chk(hit_count == 4, "R10", "total hits", hit_count, 4);

        // R6: write-back hit leaves memory alone
        access(1'b1, 12'h18B, 16'h3333, 1'b0, rd, dh, dr, dw, drd);
        chk(dh == 1 && dw == 0, "R6", "wb write hit beats", dw, 0);
        chk(mem_model[12'h18B] == init_word(12'h18B), "R6", "memory untouched",
            mem_model[12'h18B], init_word(12'h18B));

        // R5: write-through hit updates memory and cache
        access(1'b1, 12'h18C, 16'h4444, 1'b1, rd, dh, dr, dw, drd);
        chk(dh == 1 && dw == 1 && drd == 0, "R5", "wt write hit beats", dw, 1);
        chk(mem_model[12'h18C] == 16'h4444, "R5", "memory updated", mem_model[12'h18C], 16'h4444);
        access(1'b0, 12'h18C, 16'h0, 1'b0, rd, dh, dr, dw, drd);
        chk(dh == 1 && rd == 16'h4444, "R5", "cache copy updated", rd, 16'h4444);

        // R7: write-through miss does not allocate
        access(1'b1, 12'h7F0, 16'h5555, 1'b1, rd, dh, dr, dw, drd);
        chk(dh == 0 && dw == 1 && drd == 0, "R7", "wt write miss beats", drd, 0);
        access(1'b0, 12'h7F0, 16'h0, 1'b0, rd, dh, dr, dw, drd);
        chk(dh == 0 && drd == 8, "R7", "read after wt miss misses", dh, 0);
        chk(rd == 16'h5555, "R7", "read after wt miss data", rd, 16'h5555);

        // R2: reset drops the dirty line at index 1 without write-back
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hit_count == 0 && ref_count == 0, "R2", "counters after second reset", hit_count, 0);
        access(1'b0, 12'h18C, 16'h0, 1'b0, rd, dh, dr, dw, drd);
        chk(dh == 0 && dw == 0 && drd == 8, "R2", "no valid line after reset", dw, 0);
        chk(rd == 16'h4444, "R2", "data after reset", rd, 16'h4444);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule